// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C master and tells the byte engine where each bit begins, where to sample and where it ends. The low and high phase lengths come from two 9-bit counts supplied by configuration registers. The counts advance on a tick that is either the input clock or the input clock divided by two. The lower eight bits of each count arrive on their own byte-wide inputs. The ninth bits arrive on two bits of a separate control byte. Bit 7 of that byte extends the low count and bit 6 extends the high count.

The low phase is counted from the cycle the block starts pulling SCL low. The high phase is timed differently. The block releases SCL and then waits until the returning pad level, passed through a two-flop synchronizer, reads high. Only then does it start the high count. Rise time and any slave holding SCL low are therefore absent from the programmed high period.

The block also forms the START and STOP conditions. For a START it pulls SDA low and keeps SCL released for one high count. For a STOP it pulls SDA low during one low phase, releases SCL, waits for SCL to read high, waits one more high count and then releases SDA. The byte engine supplies the data bits. It combines the `sda_pull` request with its own SDA drive.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, and while no transfer is active, `scl_oe` and `sda_pull` are 0 and no phase strobe is produced. Dropping `enable` returns the block to that state at the next clock edge.
- R2: A `cmd_start` pulse in idle raises `sda_pull` while SCL stays released. `scl_oe` rises exactly NH*D cycles after `sda_pull` rises. NH is the effective high count and D is the tick divisor (1 or 2).
- R3: Each low phase holds `scl_oe` at 1 for exactly NL*D cycles, where NL is the effective low count. For a data bit, `ph_change` is 1 in the first of those cycles.
- R4: `ph_sample` (the start of the high count) appears 3 cycles after the SCL pad is first high following a release. When a slave holds SCL low, `ph_sample` is delayed by the same number of cycles.
- R5: `ph_end` is 1 exactly NH*D cycles after `ph_sample`. If no stop is pending, the next bit's low phase begins in that same cycle, with `ph_change` and `scl_oe` both 1.
- R6: The low count is {`cnt_ext`[7], `low_cnt_lo`[7:0]}. The high count is {`cnt_ext`[6], `high_cnt_lo`[7:0]}.
- R7: With `presc_div2` at 0 the counts tick every clock (D=1). With `presc_div2` at 1 they tick every second clock (D=2). The setting is captured when each phase starts.
- R8: A count of zero behaves as a count of one tick.
- R9: After a `cmd_stop` pulse during a transfer, the `ph_end` of the current bit starts a stop instead of a bit, and `ph_change` stays 0. SCL is then low for NL*D cycles with `sda_pull` at 1. It is released, and `sda_pull` falls 3+NH*D cycles after the release, returning the block to idle.
- R10: `cmd_start` has no effect while a transfer is active, and `cmd_stop` has no effect in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle |
| presc_div2 | input | 1 | 0: tick every clock, 1: tick every second clock |
| low_cnt_lo | input | 8 | Bits 7:0 of the low-phase count |
| high_cnt_lo | input | 8 | Bits 7:0 of the high-phase count |
| cnt_ext | input | 2 (bits 7:6) | Bit 7: low-count bit 8, bit 6: high-count bit 8 |
| cmd_start | input | 1 | Pulse: begin a transfer with a START |
| cmd_stop | input | 1 | Pulse: finish the transfer with a STOP after the current bit |
| scl_in | input | 1 | SCL level read back from the pad |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 requests SDA low for START/STOP |
| ph_change | output | 1 | One-cycle strobe: SDA may change (start of a data bit's low phase) |
| ph_sample | output | 1 | One-cycle strobe: SCL seen high, sample SDA |
| ph_end | output | 1 | One-cycle strobe: end of bit |

## Verification
Every result is due a fixed number of cycles after its cause. The gap from `sda_pull` to `scl_oe` is NH*D. The low phase lasts NL*D. `ph_sample` follows the pad going high by 3 cycles: two synchronizer flops plus the state register. `ph_end` follows `ph_sample` by NH*D. The STOP release follows the SCL release by 3+NH*D. The bench samples on the falling clock edge and records the cycle number at which each event is first observed. It then compares the differences between those numbers with the values computed from the programmed counts, including stretched, zero, ninth-bit and divide-by-two cases.

// File: rtl/scl_gen_pkg.sv
// Shared state encoding and state-class helpers for the SCL timing generator.
// Assumes: no other block decodes these encodings.
package scl_gen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_START_HOLD = 3'd1,
        ST_LOW        = 3'd2,
        ST_RISE       = 3'd3,
        ST_HIGH       = 3'd4,
        ST_STOP_LOW   = 3'd5,
        ST_STOP_RISE  = 3'd6,
        ST_STOP_HOLD  = 3'd7
    } scl_state_e;

    // True for states whose length is set by the phase timer.
    function automatic logic is_timed(scl_state_e s);
        return (s == ST_START_HOLD) || (s == ST_LOW) || (s == ST_HIGH) ||
               (s == ST_STOP_LOW) || (s == ST_STOP_HOLD);
    endfunction

    // True for states that pull SCL low.
    function automatic logic pulls_scl(scl_state_e s);
        return (s == ST_LOW) || (s == ST_STOP_LOW);
    endfunction

    // True for states that request SDA low (START and STOP forming).
    function automatic logic pulls_sda(scl_state_e s);
        return (s == ST_START_HOLD) || (s == ST_STOP_LOW) ||
               (s == ST_STOP_RISE) || (s == ST_STOP_HOLD);
    endfunction

    // True for states that count the low period.
    function automatic logic uses_low_count(scl_state_e s);
        return (s == ST_LOW) || (s == ST_STOP_LOW);
    endfunction

endpackage

// File: rtl/scl_pad_sync.sv
// Synchronizer chain for the SCL pad readback.
// Assumes: the pad idles high, so every stage resets to 1; STAGES >= 2.
module scl_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic level
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= pad_in;
            end
        end else begin : g_next
            // Pass the level one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/scl_phase_timer.sv
// Down counter that times one SCL phase in prescaled ticks.
// A load captures the count (zero becomes one) and the divide setting.
// expire is 1 in the last clock of the phase, so the phase lasts count*D clocks.
// Assumes: the caller holds run high for the whole phase and loads at phase entry.
module scl_phase_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             div2,
    input  logic             run,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic             half_q;
    logic             div2_q;
    logic             tick;

    assign tick   = !div2_q || half_q;
    assign expire = run && tick && (remain == ONE);

    // Load on phase entry, otherwise count ticks down to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= ONE;
            half_q <= 1'b0;
            div2_q <= 1'b0;
        end else if (load) begin
            remain <= (load_val == '0) ? ONE : load_val;
            half_q <= 1'b0;
            div2_q <= div2;
        end else if (run) begin
            half_q <= !half_q;
            if (tick && (remain != ONE)) remain <= remain - ONE;
        end
    end

endmodule

// File: rtl/scl_bit_fsm.sv
// Sequencer for START, data-bit and STOP phases; drives SCL/SDA requests
// and registers the phase strobes.
// Assumes: scl_seen is the synchronized pad level; expire comes from the
// phase timer that this module loads.
module scl_bit_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             scl_seen,
    input  logic             expire,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_run,
    output logic             scl_oe,
    output logic             sda_pull,
    output logic             ph_change,
    output logic             ph_sample,
    output logic             ph_end
);

    scl_state_e state_q, state_d;
    logic       stop_pend_q;
    logic       seen_low_q;
    logic       released_high;
    logic       entering;

    assign released_high = seen_low_q && scl_seen;
    assign entering      = (state_d != state_q);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       if (cmd_start) state_d = ST_START_HOLD;
                ST_START_HOLD: if (expire) state_d = ST_LOW;
                ST_LOW:        if (expire) state_d = ST_RISE;
                ST_RISE:       if (released_high) state_d = ST_HIGH;
                ST_HIGH:       if (expire) state_d = (stop_pend_q || cmd_stop) ? ST_STOP_LOW : ST_LOW;
                ST_STOP_LOW:   if (expire) state_d = ST_STOP_RISE;
                ST_STOP_RISE:  if (released_high) state_d = ST_STOP_HOLD;
                ST_STOP_HOLD:  if (expire) state_d = ST_IDLE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Timer control: load at entry to a timed state, run while in one.
    always_comb begin
        tmr_load = entering && is_timed(state_d);
        tmr_val  = uses_low_count(state_d) ? low_cnt : high_cnt;
        tmr_run  = is_timed(state_q);
    end

    assign scl_oe   = pulls_scl(state_q);
    assign sda_pull = pulls_sda(state_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember a stop request until the current bit ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pend_q <= 1'b0;
        end else if (!enable || (state_q == ST_IDLE) || (state_d == ST_STOP_LOW)) begin
            stop_pend_q <= 1'b0;
        end else if (cmd_stop && !pulls_sda(state_q)) begin
            stop_pend_q <= 1'b1;
        end
    end

    // Interlock: the released SCL counts as high only after a low was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_low_q <= 1'b0;
        end else if (entering && pulls_scl(state_d)) begin
            seen_low_q <= 1'b0;
        end else if (!scl_seen) begin
            seen_low_q <= 1'b1;
        end
    end

    // Registered phase strobes, one cycle at the matching state entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_change <= 1'b0;
            ph_sample <= 1'b0;
            ph_end    <= 1'b0;
        end else begin
            ph_change <= entering && (state_d == ST_LOW);
            ph_sample <= entering && (state_d == ST_HIGH);
            ph_end    <= enable && (state_q == ST_HIGH) && expire;
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
// SCL timing generator top: assembles the 9-bit counts, synchronizes the
// pad readback, and connects the sequencer to the phase timer.
// Assumes: scl_in is the open-drain SCL line; cnt_ext bit 7 extends the low
// count and bit 6 the high count.
module scl_timing_gen #(
    parameter int CNT_LO_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                presc_div2,
    input  logic [CNT_LO_W-1:0] low_cnt_lo,
    input  logic [CNT_LO_W-1:0] high_cnt_lo,
    input  logic [7:6]          cnt_ext,
    input  logic                cmd_start,
    input  logic                cmd_stop,
    input  logic                scl_in,
    output logic                scl_oe,
    output logic                sda_pull,
    output logic                ph_change,
    output logic                ph_sample,
    output logic                ph_end
);

    localparam int CNT_W = CNT_LO_W + 1;

    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic             scl_seen;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_run;
    logic             expire;

    // Join each ninth bit above its low byte.
    assign low_cnt  = {cnt_ext[7], low_cnt_lo};
    assign high_cnt = {cnt_ext[6], high_cnt_lo};

    scl_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (scl_in),
        .level  (scl_seen)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .div2     (presc_div2),
        .run      (tmr_run),
        .expire   (expire)
    );

    scl_bit_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .scl_seen  (scl_seen),
        .expire    (expire),
        .low_cnt   (low_cnt),
        .high_cnt  (high_cnt),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_run   (tmr_run),
        .scl_oe    (scl_oe),
        .sda_pull  (sda_pull),
        .ph_change (ph_change),
        .ph_sample (ph_sample),
        .ph_end    (ph_end)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
// Property checker for scl_timing_gen, attached by bind.
// Assumes: the same port names as the top module.
module scl_timing_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       presc_div2,
    input logic [7:0] low_cnt_lo,
    input logic [7:0] high_cnt_lo,
    input logic [7:6] cnt_ext,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       scl_in,
    input logic       scl_oe,
    input logic       sda_pull,
    input logic       ph_change,
    input logic       ph_sample,
    input logic       ph_end
);

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_pull && !ph_change && !ph_sample && !ph_end)); // R1

    AST_START_SCL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) && !ph_end) |-> !scl_oe); // R2

    AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ph_change |-> scl_oe); // R3

    AST_SAMPLE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ph_sample |-> (!scl_oe && $past(scl_in, 3))); // R4

    AST_SAMPLE_END_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_sample, ph_end})); // R5

    AST_STOP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_end && sda_pull) |-> !ph_change); // R9

    AST_STOP_SDA_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull) && $past(enable) && !ph_change) |-> !scl_oe); // R9

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (.*);

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
// Directed bench for scl_timing_gen; each task drives one scenario and checks it.
module scl_timing_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       presc_div2 = 1'b0;
    logic [7:0] low_cnt_lo = 8'd5;
    logic [7:0] high_cnt_lo = 8'd4;
    logic [7:6] cnt_ext = 2'b00;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_oe, sda_pull, ph_change, ph_sample, ph_end;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    assign scl_in = !scl_oe && !stretch;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_timing_gen u_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_div2(presc_div2),
        .low_cnt_lo(low_cnt_lo), .high_cnt_lo(high_cnt_lo), .cnt_ext(cnt_ext),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .scl_in(scl_in),
        .scl_oe(scl_oe), .sda_pull(sda_pull), .ph_change(ph_change),
        .ph_sample(ph_sample), .ph_end(ph_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sel_sig(input int sel);
        case (sel)
            0: return scl_oe;
            1: return sda_pull;
            2: return ph_change;
            3: return ph_sample;
            default: return ph_end;
        endcase
    endfunction

    // Wait (checking the current negedge first) until the chosen output equals val.
    task automatic wait_for(input int sel, input logic val, output int t);
        int n = 0;
        while (sel_sig(sel) !== val && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk("wait timeout", sel, -1);
        t = cyc;
    endtask

    task automatic do_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (scl_oe || sda_pull || ph_change || ph_sample || ph_end) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic stop_and_drain();
        int t;
        pulse_stop();
        wait_for(4, 1'b1, t);
        wait_for(1, 1'b1, t);
        wait_for(1, 1'b0, t);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset scl_oe", scl_oe, 0);
        chk("R1 reset sda_pull", sda_pull, 0);
        chk("R1 reset strobes", ph_change + ph_sample + ph_end, 0);
    endtask

    // One full bit, then a STOP, with all timings checked.
    task automatic t_bit(input logic [7:0] llo, input logic [7:0] hlo,
                         input logic lmsb, input logic hmsb, input logic d2, input string tag);
        int nl, nh, d, ts, tl, tr, tsm, te, t0, t1, t2;
        nl = {23'd0, lmsb, llo}; if (nl == 0) nl = 1;
        nh = {23'd0, hmsb, hlo}; if (nh == 0) nh = 1;
        d  = d2 ? 2 : 1;
        low_cnt_lo = llo; high_cnt_lo = hlo; cnt_ext = {lmsb, hmsb}; presc_div2 = d2;
        do_start();
        wait_for(1, 1'b1, ts);
        chk({tag, " R2 scl released at start"}, scl_oe, 0);
        wait_for(0, 1'b1, tl);
        chk({tag, " R2 start hold R6 R7 R8"}, tl - ts, nh * d);
        chk({tag, " R3 change at low entry"}, ph_change, 1);
        wait_for(0, 1'b0, tr);
        chk({tag, " R3 low length R6 R7 R8"}, tr - tl, nl * d);
        wait_for(3, 1'b1, tsm);
        chk({tag, " R4 sample delay"}, tsm - tr, 3);
        wait_for(4, 1'b1, te);
        chk({tag, " R5 high length"}, te - tsm, nh * d);
        chk({tag, " R5 next bit starts"}, ph_change + scl_oe, 2);
        pulse_stop();
        wait_for(4, 1'b1, t0);
        chk({tag, " R9 stop no change"}, ph_change, 0);
        chk({tag, " R9 stop sda pulled"}, sda_pull + scl_oe, 2);
        wait_for(0, 1'b0, t1);
        chk({tag, " R9 stop low length"}, t1 - t0, nl * d);
        wait_for(1, 1'b0, t2);
        chk({tag, " R9 stop release"}, t2 - t1, 3 + nh * d);
        quiet(30, {tag, " R1 idle after stop"});
    endtask

    task automatic t_stretch();
        int tr, tp, tsm;
        low_cnt_lo = 8'd20; high_cnt_lo = 8'd4; cnt_ext = 2'b00; presc_div2 = 1'b0;
        do_start();
        wait_for(0, 1'b1, tr);
        stretch = 1'b1;
        wait_for(0, 1'b0, tr);
        repeat (10) @(negedge clk);
        chk("R4 no sample while stretched", ph_sample, 0);
        stretch = 1'b0;
        tp = cyc;
        wait_for(3, 1'b1, tsm);
        chk("R4 sample after stretch release", tsm - tp, 3);
        chk("R4 stretch total", tsm - tr, 13);
        stop_and_drain();
    endtask

    task automatic t_disable();
        int t;
        low_cnt_lo = 8'd30; high_cnt_lo = 8'd30; cnt_ext = 2'b00; presc_div2 = 1'b0;
        do_start();
        wait_for(0, 1'b1, t);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable releases", scl_oe + sda_pull, 0);
        quiet(40, "R1 disabled quiet");
        enable = 1'b1;
        quiet(20, "R1 re-enabled idle");
    endtask

    task automatic t_ignored();
        int tl, tr, te;
        @(negedge clk);
        pulse_stop();
        quiet(30, "R10 stop in idle ignored");
        low_cnt_lo = 8'd10; high_cnt_lo = 8'd10; cnt_ext = 2'b00; presc_div2 = 1'b0;
        do_start();
        wait_for(0, 1'b1, tl);
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        wait_for(0, 1'b0, tr);
        chk("R10 low unaffected by start", tr - tl, 10);
        wait_for(4, 1'b1, te);
        chk("R10 bit continues", ph_change, 1);
        chk("R10 no sda pull", sda_pull, 0);
        stop_and_drain();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        enable = 1'b1;
        t_bit(8'd5, 8'd4, 1'b0, 1'b0, 1'b0, "base");
        t_bit(8'd3, 8'd2, 1'b0, 1'b0, 1'b1, "div2");
        t_bit(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, "zero");
        t_bit(8'd0, 8'd0, 1'b0, 1'b0, 1'b1, "zero div2");
        t_bit(8'd0, 8'd5, 1'b1, 1'b1, 1'b0, "ninth bit");
        t_stretch();
        t_disable();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule